// File: doc/BRIEF.md
# Gated Two-Tone / On-Off Identity Beacon

This block repeatedly broadcasts a 16-bit identity value as a square-wave carrier. A fast clock stands in for a delay line. Each identity bit sets how many fast-clock cycles the carrier waits between toggles. In two-tone mode a 0 bit gives a short half-period and a 1 bit a longer one. In on-off mode a 1 bit gives a single tone and a 0 bit gives a silent carrier.

Transmission runs only while the enable input is high. On each rising edge of enable the identity value is captured and sent most significant bit first. The word then repeats without a gap for as long as enable stays high. The bit rate is set entirely by an external strobe, so the same block serves base, 2x, 4x and 16x rates. Two one-cycle flags mark bit boundaries and the start of each repetition.

Top module: `idb_beacon`

## Requirements
- R1: In two-tone mode (`mode_sel` = 0), a 0 bit makes the carrier toggle every N+1 fast-clock cycles, where N is `n_sel`.
- R2: In two-tone mode, a 1 bit makes the carrier toggle every N+K+1 cycles, where K is `k_sel`. This is always slower than the 0-bit tone.
- R3: In on-off mode (`mode_sel` = 1), a 1 bit makes the carrier toggle every N+1 cycles. A 0 bit holds the carrier low, and K has no effect.
- R4: While `tx_en` is low, the carrier is held low from the second cycle on and both flags stay low, whatever the other inputs do.
- R5: When `tx_en` rises, `id_word` is captured and sent from bit 15 down to bit 0, then repeated cyclically. Later changes to `id_word` do not affect a transmission in progress.
- R6: While enabled, the current bit advances by exactly one position for each cycle in which `bit_stb` is high, and never without a strobe.
- R7: `bit_mark` pulses for one cycle in the first cycle of every bit, including the first bit after enable. `word_mark` pulses together with it whenever bit 15 begins.
- R8: N, K and the mode are captured only while `tx_en` is low. Changing them while enabled does not alter the carrier.
- R9: After synchronous reset the carrier and both flags are low.
- R10: Supported ranges are N from 0 to 6 and K from 1 to 10. The half-period counter restarts whenever the bit value changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | fast clock that stands in for the delay element |
| rst | input | 1 | synchronous active-high reset |
| tx_en | input | 1 | transmission enable; low forces silence |
| bit_stb | input | 1 | one-cycle strobe that advances to the next identity bit |
| mode_sel | input | 1 | 0 = two-tone, 1 = on-off keying |
| n_sel | input | 3 | base delay N |
| k_sel | input | 4 | extra delay K for 1 bits in two-tone mode |
| id_word | input | 16 | identity value to broadcast |
| carrier | output | 1 | modulated square wave |
| bit_mark | output | 1 | first cycle of each bit |
| word_mark | output | 1 | first cycle of each repetition (bit 15) |

## Verification
The hardest condition to create from the ports is a configuration or identity change in the middle of a live transmission. The bench reaches it by altering N, K, mode and identity five bits into a stream. It then decodes the whole carrier again and expects the original word. Decoding measures the interval between toggles inside each bit slot and compares it with N+1 and N+K+1. In on-off mode it counts toggles instead. Each run spans more than two repetitions, at strobe spacings that reach the tightest slot where the 16x rate still leaves two toggles per bit.

// File: rtl/idb_pkg.sv
package idb_pkg;

    localparam int ID_W  = 16;
    localparam int N_W   = 3;
    localparam int K_W   = 4;
    localparam int CNT_W = 5;

    typedef enum logic {
        MODE_FSK = 1'b0,
        MODE_OOK = 1'b1
    } mode_e;

    typedef struct packed {
        mode_e          mode;
        logic [N_W-1:0] n;
        logic [K_W-1:0] k;
    } cfg_t;

    // Cycles between carrier toggles for the given bit value.
    function automatic logic [CNT_W-1:0] half_len(cfg_t c, logic bit_v);
        logic [CNT_W-1:0] len;
        len = CNT_W'(c.n) + CNT_W'(1);
        if (c.mode == MODE_FSK && bit_v) begin
            len = len + CNT_W'(c.k);
        end
        return len;
    endfunction

endpackage

// File: rtl/idb_cfg_hold.sv
module idb_cfg_hold
    import idb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tx_en,
    input  cfg_t cfg_in,
    output cfg_t cfg_q
);

    // Settings follow the inputs only while idle; frozen during a burst.
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '{mode: MODE_FSK, n: '0, k: K_W'(1)};
        end else if (!tx_en) begin
            cfg_q <= cfg_in;
        end
    end

endmodule

// File: rtl/idb_id_rotor.sv
module idb_id_rotor #(
    parameter int ID_W = idb_pkg::ID_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tx_en,
    input  logic            bit_stb,
    input  logic [ID_W-1:0] id_word,
    output logic            act,
    output logic            cur_bit,
    output logic            bit_mark,
    output logic            word_mark
);

    localparam int IDX_W = $clog2(ID_W);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ID_W - 1);

    logic [ID_W-1:0]  sreg;
    logic [IDX_W-1:0] idx;
    logic             start;
    logic             adv;

    assign start   = tx_en && !act;
    assign adv     = tx_en && act && bit_stb;
    assign cur_bit = sreg[ID_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            act       <= 1'b0;
            sreg      <= '0;
            idx       <= '0;
            bit_mark  <= 1'b0;
            word_mark <= 1'b0;
        end else begin
            act       <= tx_en;
            bit_mark  <= start || adv;
            word_mark <= start || (adv && idx == LAST);
            if (start) begin
                sreg <= id_word;
                idx  <= '0;
            end else if (adv) begin
                sreg <= {sreg[ID_W-2:0], sreg[ID_W-1]};
                idx  <= (idx == LAST) ? '0 : idx + IDX_W'(1);
            end
        end
    end

endmodule

// File: rtl/idb_tone_gen.sv
module idb_tone_gen
    import idb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic act,
    input  logic cur_bit,
    input  cfg_t cfg,
    output logic carrier
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] len;
    logic             bit_q;
    logic             silent;
    logic             restart;
    logic             wrap;

    assign len     = half_len(cfg, cur_bit);
    assign silent  = !act || (cfg.mode == MODE_OOK && !cur_bit);
    assign restart = cur_bit != bit_q;
    assign wrap    = cnt == len - CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            carrier <= 1'b0;
            cnt     <= '0;
            bit_q   <= 1'b0;
        end else begin
            bit_q <= act ? cur_bit : 1'b0;
            if (silent) begin
                carrier <= 1'b0;
                cnt     <= '0;
            end else if (restart) begin
                cnt <= '0;
            end else if (wrap) begin
                cnt     <= '0;
                carrier <= !carrier;
            end else begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/idb_beacon.sv
module idb_beacon
    import idb_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            tx_en,
    input  logic            bit_stb,
    input  logic            mode_sel,
    input  logic [N_W-1:0]  n_sel,
    input  logic [K_W-1:0]  k_sel,
    input  logic [ID_W-1:0] id_word,
    output logic            carrier,
    output logic            bit_mark,
    output logic            word_mark
);

    cfg_t cfg_in;
    cfg_t cfg_q;
    logic act;
    logic cur_bit;

    assign cfg_in = '{mode: mode_e'(mode_sel), n: n_sel, k: k_sel};

    idb_cfg_hold u_cfg (
        .clk    (clk),
        .rst    (rst),
        .tx_en  (tx_en),
        .cfg_in (cfg_in),
        .cfg_q  (cfg_q)
    );

    idb_id_rotor #(.ID_W(ID_W)) u_rotor (
        .clk       (clk),
        .rst       (rst),
        .tx_en     (tx_en),
        .bit_stb   (bit_stb),
        .id_word   (id_word),
        .act       (act),
        .cur_bit   (cur_bit),
        .bit_mark  (bit_mark),
        .word_mark (word_mark)
    );

    idb_tone_gen u_tone (
        .clk     (clk),
        .rst     (rst),
        .act     (act),
        .cur_bit (cur_bit),
        .cfg     (cfg_q),
        .carrier (carrier)
    );

endmodule

// File: rtl/idb_beacon_chk.sv
module idb_beacon_chk
    import idb_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic tx_en,
    input logic bit_stb,
    input logic carrier,
    input logic bit_mark,
    input logic word_mark,
    input logic act,
    input logic cur_bit,
    input cfg_t cfg_q
);

    p_idle_silent_r4: assert property (@(posedge clk) disable iff (rst)
        !tx_en |=> ##1 !carrier);

    p_idle_flags_r4: assert property (@(posedge clk) disable iff (rst)
        !tx_en |=> (!bit_mark && !word_mark));

    p_word_in_bit_r7: assert property (@(posedge clk) disable iff (rst)
        word_mark |-> bit_mark);

    p_mark_cause_r6: assert property (@(posedge clk) disable iff (rst)
        bit_mark |-> ($past(tx_en) && ($past(bit_stb) || !$past(act))));

    p_cfg_frozen_r8: assert property (@(posedge clk) disable iff (rst)
        tx_en |=> $stable(cfg_q));

    p_ook_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (act && cfg_q.mode == MODE_OOK && !cur_bit) |=> !carrier);

endmodule

bind idb_beacon idb_beacon_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .tx_en     (tx_en),
    .bit_stb   (bit_stb),
    .carrier   (carrier),
    .bit_mark  (bit_mark),
    .word_mark (word_mark),
    .act       (act),
    .cur_bit   (cur_bit),
    .cfg_q     (cfg_q)
);

// File: tb/idb_beacon_test.sv
module idb_beacon_test;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 6;

    // {mode, N, K, id, strobe spacing, expected 0-bit half, expected 1-bit half}
    localparam logic [49:0] VECS [NVEC] = '{
        {1'b0, 3'd6, 4'd10, 16'h51F3, 16'd160, 5'd7, 5'd17},
        {1'b0, 3'd2, 4'd3,  16'hA5C3, 16'd80,  5'd3, 5'd6},
        {1'b1, 3'd3, 4'd5,  16'h51F3, 16'd40,  5'd0, 5'd4},
        {1'b0, 3'd0, 4'd1,  16'h8001, 16'd10,  5'd1, 5'd2},
        {1'b1, 3'd0, 4'd1,  16'h7FFE, 16'd10,  5'd0, 5'd1},
        {1'b0, 3'd4, 4'd1,  16'hFFFF, 16'd40,  5'd5, 5'd6}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tx_en = 1'b0;
    logic        bit_stb = 1'b0;
    logic        mode_sel = 1'b0;
    logic [2:0]  n_sel = '0;
    logic [3:0]  k_sel = 4'd1;
    logic [15:0] id_word = '0;
    logic        carrier;
    logic        bit_mark;
    logic        word_mark;

    int total = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    idb_beacon uut (
        .clk       (clk),
        .rst       (rst),
        .tx_en     (tx_en),
        .bit_stb   (bit_stb),
        .mode_sel  (mode_sel),
        .n_sel     (n_sel),
        .k_sel     (k_sel),
        .id_word   (id_word),
        .carrier   (carrier),
        .bit_mark  (bit_mark),
        .word_mark (word_mark)
    );

    task automatic ck(input bit ok, input string tag, input int act_v, input int exp_v);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act_v, exp_v);
        end
    endtask

    function automatic bit slot_ok(input logic md, input logic [15:0] id, input int slot,
                                   input int tc, input int iv, input int h0, input int h1);
        logic e;
        e = id[15 - (slot % 16)];
        if (!md) return (tc >= 2) && (iv == (e ? h1 : h0));
        return e ? ((tc >= 2) && (iv == h1)) : (tc <= 1);
    endfunction

    task automatic run_stream(input logic md, input logic [2:0] nn, input logic [3:0] kk,
                              input logic [15:0] id, input int per, input int h0, input int h1,
                              input bit disturb, output int bad, output int wbad, output int nslot);
        int slot, tc, iv, last_t;
        logic last_car;
        @(negedge clk);
        tx_en = 1'b0; bit_stb = 1'b0;
        mode_sel = md; n_sel = nn; k_sel = kk; id_word = id;
        repeat (3) @(negedge clk);
        tx_en = 1'b1;
        bad = 0; wbad = 0; slot = -1; tc = 0; iv = 0; last_t = 0; last_car = 1'b0;
        for (int cyc = 1; cyc < 34 * per + 40 && slot < 33; cyc++) begin
            @(negedge clk);
            if (carrier !== last_car) begin
                if (slot >= 0) begin
                    if (tc > 0 && iv == 0) iv = cyc - last_t;
                    tc++;
                    last_t = cyc;
                end
                last_car = carrier;
            end
            if (bit_mark) begin
                if (slot >= 0 && !slot_ok(md, id, slot, tc, iv, h0, h1)) bad++;
                slot++; tc = 0; iv = 0;
                if (word_mark !== ((slot % 16) == 0)) wbad++;
            end
            bit_stb = (cyc % per) == 0;
            if (disturb && slot == 5) begin
                mode_sel = ~md; n_sel = ~nn; k_sel = ~kk; id_word = ~id;
            end
        end
        nslot = slot;
        tx_en = 1'b0; bit_stb = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++; total++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        int bad, wbad, nslot, cnt_hi, cnt_mk;
        // R9: reset state
        repeat (4) @(negedge clk);
        ck(carrier == 1'b0 && bit_mark == 1'b0 && word_mark == 1'b0, "R9 reset outputs",
           {carrier, bit_mark, word_mark}, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // Table-driven streams: R1 R2 R3 R5 R6 R7 R10
        for (int v = 0; v < NVEC; v++) begin
            run_stream(VECS[v][49], VECS[v][48:46], VECS[v][45:42], VECS[v][41:26],
                       int'(VECS[v][25:10]), int'(VECS[v][9:5]), int'(VECS[v][4:0]),
                       1'b0, bad, wbad, nslot);
            ck(bad == 0, VECS[v][49] ? "R3 R5 on-off stream" : "R1 R2 R5 R10 two-tone stream", bad, 0);
            ck(nslot == 33, "R6 bits per strobe", nslot, 33);
            ck(wbad == 0, "R7 word marks", wbad, 0);
        end

        // R8 and R5: settings and identity altered mid-burst are ignored
        run_stream(1'b0, 3'd1, 4'd2, 16'h51F3, 40, 2, 4, 1'b1, bad, wbad, nslot);
        ck(bad == 0, "R8 mid-burst change ignored", bad, 0);
        ck(nslot == 33, "R5 stream length after change", nslot, 33);

        // R4: idle silence while other inputs toggle
        repeat (2) @(negedge clk);
        cnt_hi = 0; cnt_mk = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (carrier) cnt_hi++;
            if (bit_mark || word_mark) cnt_mk++;
            bit_stb = i[0]; mode_sel = i[1]; n_sel = 3'(i); id_word = 16'(i * 77);
        end
        bit_stb = 1'b0;
        ck(cnt_hi == 0, "R4 carrier idle", cnt_hi, 0);
        ck(cnt_mk == 0, "R4 flags idle", cnt_mk, 0);

        // R6: no strobe, no advance
        mode_sel = 1'b0; n_sel = 3'd0; k_sel = 4'd1; id_word = 16'h51F3;
        repeat (2) @(negedge clk);
        tx_en = 1'b1;
        cnt_mk = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (bit_mark) cnt_mk++;
        end
        ck(cnt_mk == 1, "R6 only start mark without strobe", cnt_mk, 1);
        tx_en = 1'b0;
        repeat (3) @(negedge clk);
        ck(carrier == 1'b0, "R4 carrier after disable", carrier, 0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule